// File: doc/BRIEF.md
# Triple Redundancy Voter with Reconfiguration Request

This block sits behind three identical copies of a user function. It merges their output words into one result, taking each bit from the majority, so a single faulty copy does not disturb the output. A system controller can then schedule the repair of that copy later instead of stopping the function at once.

Alongside the vote, the block looks for a copy that disagrees with the other two. Each copy also has a configuration checker that can raise an error flag, and the block watches those flags too. When it finds a fault it reports which copy is at fault, or reports that more than one copy is involved, and raises a reconfiguration request. That request stays high until the controller acknowledges it. The controller can mask a copy that is under repair. The block then excludes that copy from the vote and from fault detection, and checks only that the two remaining copies agree.

All outputs are registered, so each one follows its inputs by one clock.

Top module: `tmr_voter`

## Requirements
- R1: With no copy masked, each bit of `voted_o` equals the value that at least two of the three copies hold in that bit.
- R2: With no copy masked, a copy whose word differs from the voted word raises `reconf_req_o` on the next clock.
- R3: An asserted `cfg_err_i[k]` for an unmasked copy k raises `reconf_req_o` on the next clock, just as a disagreement does.
- R4: `fault_id_o` is 2'd0 when no copy is suspect and no fault is reported. It is 2'd1, 2'd2 or 2'd3 when copy A, B or C (mask and error bits 0, 1 and 2) is the only suspect copy. A copy is suspect when it is unmasked and either disagrees or has its error flag set.
- R5: `multi_fault_o` is high when two or more unmasked copies are suspect at the same time, and `fault_id_o` is then 2'd0.
- R6: Once high, `reconf_req_o` stays high through any number of cycles until a cycle in which `ack_i` is high and no fault is present. It is low on the next clock after that cycle.
- R7: If `ack_i` is high in a cycle that also has a fault, `reconf_req_o` stays high.
- R8: With exactly one copy masked, `voted_o` is the lower-indexed unmasked copy. A mismatch between the two unmasked copies raises the request, sets `multi_fault_o` and leaves `fault_id_o` at 2'd0.
- R9: A masked copy's data and error flag have no effect on any output. With two copies masked, `voted_o` is the only unmasked copy and only that copy's error flag counts.
- R10: With all three copies masked, `voted_o` is zero and no new fault is reported.
- R11: While `rst_ni` is low, all outputs are zero.
- R12: The outputs change only on a rising clock edge, one cycle after their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| copy_a_i | input | DATA_W | Output word of copy A (index 0) |
| copy_b_i | input | DATA_W | Output word of copy B (index 1) |
| copy_c_i | input | DATA_W | Output word of copy C (index 2) |
| cfg_err_i | input | 3 | Configuration error flag per copy, bit k for copy k |
| mask_i | input | 3 | Copy excluded from vote and detection, bit k for copy k |
| ack_i | input | 1 | Acknowledge from the system controller |
| voted_o | output | DATA_W | Voted output word |
| fault_id_o | output | 2 | Single suspect copy, 0 = none, 1..3 = A..C |
| multi_fault_o | output | 1 | More than one copy suspect, or the unmasked pair disagrees |
| reconf_req_o | output | 1 | Sticky reconfiguration request |

## Verification
The bench builds the block with DATA_W = 4. At that width every combination of the three copy words can be applied with no copy masked, which covers every pattern of per-bit agreement and disagreement. The bench then sweeps all eight mask patterns against all eight error-flag patterns, using a set of data words in which each copy is either equal to or different from the others. Acknowledge pulses fall at regular intervals through both sweeps. As a result the request latch meets acknowledges with and without a fault in the same cycle, under every mask setting.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCOPY = 3;
  typedef logic [1:0] fault_id_t;
  typedef logic [NCOPY-1:0] copy_vec_t;
endpackage

// File: rtl/tmr_vote.sv
module tmr_vote
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [NCOPY-1:0][DATA_W-1:0] copies_i,
  input  copy_vec_t                    mask_i,
  output logic [DATA_W-1:0]            voted_o,
  output copy_vec_t                    disagree_o,
  output logic                         pair_mm_o
);
  logic [DATA_W-1:0] maj;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_bit
      assign maj[gi] = (copies_i[0][gi] & copies_i[1][gi]) |
                       (copies_i[0][gi] & copies_i[2][gi]) |
                       (copies_i[1][gi] & copies_i[2][gi]);
    end
  endgenerate

  logic [1:0] first_idx, second_idx;
  logic [1:0] n_live;

  // lowest and next-lowest unmasked copies
  always_comb begin
    first_idx  = '0;
    second_idx = '0;
    n_live     = '0;
    for (int k = NCOPY - 1; k >= 0; k--) begin
      if (!mask_i[k]) begin
        second_idx = first_idx;
        first_idx  = 2'(k);
        n_live     = n_live + 2'd1;
      end
    end
  end

  always_comb begin
    voted_o    = '0;
    disagree_o = '0;
    pair_mm_o  = 1'b0;
    case (n_live)
      2'd3: begin
        voted_o = maj;
        for (int k = 0; k < NCOPY; k++) disagree_o[k] = (copies_i[k] != maj);
      end
      2'd2: begin
        voted_o   = copies_i[first_idx];
        pair_mm_o = (copies_i[first_idx] != copies_i[second_idx]);
      end
      2'd1:    voted_o = copies_i[first_idx];
      default: voted_o = '0;
    endcase
  end

  // R1
  always_comb begin
    if (mask_i == '0 && copies_i[0] == copies_i[1])
      unanimous_pair_chk: assert (voted_o == copies_i[0]);
  end
endmodule

// File: rtl/tmr_fault_detect.sv
module tmr_fault_detect
  import tmr_pkg::*;
(
  input  copy_vec_t disagree_i,
  input  copy_vec_t err_i,
  input  copy_vec_t mask_i,
  input  logic      pair_mm_i,
  output logic      event_o,
  output fault_id_t fault_id_o,
  output logic      multi_o
);
  copy_vec_t suspect;
  logic [1:0] n_sus;

  assign suspect = (disagree_i | err_i) & ~mask_i;

  always_comb begin
    n_sus = '0;
    for (int k = 0; k < NCOPY; k++) n_sus = n_sus + 2'(suspect[k]);
  end

  assign event_o = (|suspect) | pair_mm_i;
  assign multi_o = (n_sus >= 2'd2) | pair_mm_i;

  always_comb begin
    fault_id_o = '0;
    if (!multi_o && n_sus == 2'd1) begin
      for (int k = 0; k < NCOPY; k++)
        if (suspect[k]) fault_id_o = fault_id_t'(k + 1);
    end
  end

  // R5
  always_comb begin
    multi_excl_chk: assert (!(multi_o && fault_id_o != '0));
  end

  // R9
  always_comb begin
    if (fault_id_o != '0)
      id_unmasked_chk: assert (!mask_i[fault_id_o - 2'd1]);
  end
endmodule

// File: rtl/tmr_req_latch.sv
module tmr_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic ack_i,
  output logic req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      req_o <= 1'b0;
    else if (event_i) req_o <= 1'b1;
    else if (ack_i)   req_o <= 1'b0;
  end

  // R2
  req_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i |=> req_o);

  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> req_o);

  // R6
  req_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !event_i) |=> !req_o);

  // R7
  req_ack_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && event_i) |=> req_o);
endmodule

// File: rtl/tmr_voter.sv
module tmr_voter
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] copy_a_i,
  input  logic [DATA_W-1:0] copy_b_i,
  input  logic [DATA_W-1:0] copy_c_i,
  input  logic [2:0]        cfg_err_i,
  input  logic [2:0]        mask_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] voted_o,
  output logic [1:0]        fault_id_o,
  output logic              multi_fault_o,
  output logic              reconf_req_o
);
  logic [NCOPY-1:0][DATA_W-1:0] copies;
  logic [DATA_W-1:0] voted_d;
  copy_vec_t         disagree;
  logic              pair_mm;
  logic              fault_event;
  fault_id_t         fault_id_d;
  logic              multi_d;

  assign copies = {copy_c_i, copy_b_i, copy_a_i};

  tmr_vote #(.DATA_W(DATA_W)) u_vote (
    .copies_i   (copies),
    .mask_i     (mask_i),
    .voted_o    (voted_d),
    .disagree_o (disagree),
    .pair_mm_o  (pair_mm)
  );

  tmr_fault_detect u_detect (
    .disagree_i (disagree),
    .err_i      (cfg_err_i),
    .mask_i     (mask_i),
    .pair_mm_i  (pair_mm),
    .event_o    (fault_event),
    .fault_id_o (fault_id_d),
    .multi_o    (multi_d)
  );

  tmr_req_latch u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .event_i (fault_event),
    .ack_i   (ack_i),
    .req_o   (reconf_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      voted_o       <= '0;
      fault_id_o    <= '0;
      multi_fault_o <= 1'b0;
    end else begin
      voted_o       <= voted_d;
      fault_id_o    <= fault_id_d;
      multi_fault_o <= multi_d;
    end
  end

  // R12
  unanimous_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == 3'b000 && copy_a_i == copy_b_i && copy_b_i == copy_c_i)
      |=> (voted_o == $past(copy_a_i)));

  // R3
  err_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg_err_i & ~mask_i) != 3'b000) |=> reconf_req_o);

  // R10
  all_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == 3'b111) |=> (voted_o == '0 && fault_id_o == '0 && !multi_fault_o));
endmodule

// File: tb/sim_tmr_voter.sv
module sim_tmr_voter;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0, c = '0;
  logic [2:0] err = '0, msk = '0;
  logic ack = 1'b0;
  logic [W-1:0] voted;
  logic [1:0] fid;
  logic multi, req;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;
  logic req_exp = 1'b0;

  always #4 clk = ~clk;

  tmr_voter #(.DATA_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .copy_a_i(a), .copy_b_i(b), .copy_c_i(c),
    .cfg_err_i(err), .mask_i(msk), .ack_i(ack),
    .voted_o(voted), .fault_id_o(fid),
    .multi_fault_o(multi), .reconf_req_o(req)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [W-1:0] va, vb, vc,
                         input logic [2:0] ve, vm, input logic vk);
    logic [W-1:0] w [3];
    logic [W-1:0] vexp;
    logic [2:0] live, dis, sus;
    int n, f, s, ns, idexp;
    logic pm, ev, mexp;
    string vtag, rtag;
    w[0] = va; w[1] = vb; w[2] = vc;
    live = ~vm;
    n = 0; f = -1; s = -1;
    for (int k = 0; k < 3; k++)
      if (live[k]) begin
        n++;
        if (f < 0) f = k; else if (s < 0) s = k;
      end
    dis = '0; pm = 1'b0; vexp = '0;
    if (n == 3) begin
      for (int i = 0; i < W; i++)
        vexp[i] = (int'(va[i]) + int'(vb[i]) + int'(vc[i])) >= 2;
      for (int k = 0; k < 3; k++) dis[k] = (w[k] != vexp);
    end else if (n == 2) begin
      vexp = w[f]; pm = (w[f] != w[s]);
    end else if (n == 1) vexp = w[f];
    sus = (dis | ve) & live;
    ns = int'(sus[0]) + int'(sus[1]) + int'(sus[2]);
    ev = (ns > 0) || pm;
    mexp = (ns >= 2) || pm;
    idexp = 0;
    if (!mexp && ns == 1)
      for (int k = 0; k < 3; k++) if (sus[k]) idexp = k + 1;
    vtag = (n == 3) ? "R1" : (n == 2) ? "R8" : (n == 1) ? "R9" : "R10";
    if (ev && vk) rtag = "R7";
    else if (ev && (ve & live) != 0) rtag = "R3";
    else if (ev) rtag = "R2";
    else rtag = "R6";
    a = va; b = vb; c = vc; err = ve; msk = vm; ack = vk;
    @(posedge clk); #2;
    req_exp = ev ? 1'b1 : (vk ? 1'b0 : req_exp);
    check({vtag, " voted"}, int'(voted), int'(vexp));
    check("R4 fault_id", int'(fid), idexp);
    check(pm ? "R8 multi" : "R5 multi", int'(multi), int'(mexp));
    check({rtag, " request"}, int'(req), int'(req_exp));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R11
    check("R11 voted reset", int'(voted), 0);
    check("R11 fault_id reset", int'(fid), 0);
    check("R11 multi reset", int'(multi), 0);
    check("R11 request reset", int'(req), 0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    // R12: no change before the edge
    a = 4'd5; b = 4'd5; c = 4'd5;
    #2;
    check("R12 voted before edge", int'(voted), 0);
    @(posedge clk); #2;
    check("R12 voted after edge", int'(voted), 5);
    // R2 directed: copy B differs
    run_vec(4'd9, 4'd1, 4'd9, 3'b000, 3'b000, 1'b0);
    check("R2 id copy B", int'(fid), 2);
    // R6: hold through clean cycles without ack
    for (int i = 0; i < 4; i++) run_vec(4'd3, 4'd3, 4'd3, 3'b000, 3'b000, 1'b0);
    check("R6 held", int'(req), 1);
    run_vec(4'd3, 4'd3, 4'd3, 3'b000, 3'b000, 1'b1);
    check("R6 cleared", int'(req), 0);
    // R3 directed: error flag on C alone
    run_vec(4'd6, 4'd6, 4'd6, 3'b100, 3'b000, 1'b0);
    check("R3 id copy C", int'(fid), 3);
    // R7 directed: ack with fault
    run_vec(4'd6, 4'd6, 4'd6, 3'b001, 3'b000, 1'b1);
    check("R7 kept", int'(req), 1);
    // R9 directed: masked copy wildly different and flagging
    run_vec(4'd6, 4'd6, 4'd6, 3'b000, 3'b000, 1'b1);
    run_vec(4'd15, 4'd2, 4'd2, 3'b001, 3'b001, 1'b0);
    check("R9 masked ignored", int'(req), 0);

    for (int i = 0; i < 4096; i++)
      run_vec(W'(i), W'(i >> 4), W'(i >> 8), 3'b000, 3'b000, (i % 5) == 0);
    for (int m = 0; m < 8; m++)
      for (int e = 0; e < 8; e++)
        for (int j = 0; j < 32; j++) begin
          logic [W-1:0] xa, xb, xc;
          xa = W'(j * 5);
          xb = j[0] ? W'(j * 11 + 3) : xa;
          xc = j[1] ? W'(j * 3 + 7) : xa;
          if (j[2]) xb = xa;
          run_vec(xa, xb, xc, 3'(e), 3'(m), (j % 3) == 0);
        end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule